// File: doc/BRIEF.md
# Tiled Two-Dimensional Address Generator

This block turns a tile description of a two-dimensional sample buffer into the stream of linear sample addresses that a DMA engine walks when it moves the buffer tile by tile. At run time it takes the buffer size, the tile size, a start offset in each dimension and a short list of traversal levels. Each level names the dimension it steps along, the number of samples the tile origin moves per step, and how many steps it takes before it starts again.

A start pulse latches the configuration. The block spends one cycle checking that every coordinate the walk could reach lies inside the buffer. It then streams one address per accepted handshake. Inside a tile, dimension 0 changes fastest. Traversal level 0 is the innermost tile loop, and each later level wraps around the ones before it. Strides smaller than the tile size make tiles overlap, and the shared samples are emitted again. Each address comes with a flag for the end of its tile and a flag for the end of the whole transfer. After the last address the block goes back to idle. A configuration that would leave the buffer emits nothing and raises an error flag.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `busy_o` and `cfg_err_o` are low.
- R2: Each address equals x + y*buf_dim0, where x = offset0 + tile origin along dimension 0 + position in tile along dimension 0, and y is formed the same way for dimension 1. Inside a tile the position along dimension 0 runs fastest, from 0 to tile_dim0-1.
- R3: Traversal level k uses the dimension given by bit k of `trav_dim_i` (0 or 1), the stride in bits [k*8 +: 8] of `trav_stride_i` and the wrap count in bits [k*4 +: 4] of `trav_wrap_i`. Level 0 is the innermost tile loop. The origin of a level moves by its stride once per completed pass of the loops inside it, and returns to zero after wrap steps.
- R4: When a stride is smaller than the tile size in its dimension, the overlapping samples are emitted again for each tile that covers them.
- R5: A good configuration produces exactly tile_dim0*tile_dim1*wrap0*wrap1 addresses. `last_o` is high only on the final one, and `busy_o` falls in the cycle after that address is accepted.
- R6: `tile_last_o` is high exactly on the final address of each tile.
- R7: The address counters advance only when `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, the address and flags stay unchanged.
- R8: If a tile dimension or a wrap count is zero, or if any coordinate the walk could reach is at or beyond the buffer size in its dimension, `cfg_err_o` goes high, no address is emitted, and the block returns to idle. `cfg_err_o` is cleared by the next accepted start.
- R9: A start pulse received while `busy_o` is high is ignored. The running sequence continues unchanged, and the configuration presented with that pulse is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches the configuration when idle |
| buf_dim0_i | input | 8 | Buffer size along dimension 0 |
| buf_dim1_i | input | 8 | Buffer size along dimension 1 |
| tile_dim0_i | input | 8 | Tile size along dimension 0 |
| tile_dim1_i | input | 8 | Tile size along dimension 1 |
| offset0_i | input | 8 | Start offset along dimension 0 |
| offset1_i | input | 8 | Start offset along dimension 1 |
| trav_dim_i | input | 2 | Dimension selected by each traversal level |
| trav_stride_i | input | 16 | Stride of each traversal level, 8 bits per level |
| trav_wrap_i | input | 8 | Wrap count of each traversal level, 4 bits per level |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | Address is valid |
| addr_o | output | 16 | Linear sample address |
| tile_last_o | output | 1 | Final address of the current tile |
| last_o | output | 1 | Final address of the transfer |
| busy_o | output | 1 | Checking or streaming |
| cfg_err_o | output | 1 | Last accepted configuration was out of range |

## Verification
The hardest situation to reach is a stall or a late start pulse that lands exactly where the level carries ripple: the end of a tile that is also the wrap point of level 0, with overlapping tiles, so that the same address appears twice for two different reasons. The bench reaches it with a near-exhaustive sweep. It covers tile sizes, strides, wrap counts and dimension assignments, including both levels on one dimension, over a small buffer, under a ready pattern that drifts against the address index. It replays both worked tiling examples, and it presents out-of-range and zero-sized configurations, with the expected sequence or the expected error computed from nested loops in the bench.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } state_e;
endpackage

// File: rtl/tile_addr_cfg_check.sv
module tile_addr_cfg_check #(
  parameter int DIM_W   = 8,
  parameter int WRAP_W  = 4,
  parameter int NUM_LVL = 2,
  parameter int EXT_W   = 16
) (
  input  logic [DIM_W-1:0]          buf0_i,
  input  logic [DIM_W-1:0]          buf1_i,
  input  logic [DIM_W-1:0]          tile0_i,
  input  logic [DIM_W-1:0]          tile1_i,
  input  logic [DIM_W-1:0]          off0_i,
  input  logic [DIM_W-1:0]          off1_i,
  input  logic [NUM_LVL-1:0]        dim_i,
  input  logic [NUM_LVL*DIM_W-1:0]  stride_i,
  input  logic [NUM_LVL*WRAP_W-1:0] wrap_i,
  output logic                      err_o
);
  logic [EXT_W-1:0] end0, end1;
  logic             zero_bad;

  // end_d = one past the highest coordinate reachable along dimension d
  always_comb begin
    end0     = EXT_W'(off0_i) + EXT_W'(tile0_i);
    end1     = EXT_W'(off1_i) + EXT_W'(tile1_i);
    zero_bad = (tile0_i == '0) || (tile1_i == '0);
    for (int l = 0; l < NUM_LVL; l++) begin
      logic [EXT_W-1:0]  st;
      logic [WRAP_W-1:0] wr;
      st = EXT_W'(stride_i[l*DIM_W +: DIM_W]);
      wr = wrap_i[l*WRAP_W +: WRAP_W];
      if (wr == '0) zero_bad = 1'b1;
      else if (dim_i[l]) end1 = end1 + st * EXT_W'(wr - WRAP_W'(1));
      else               end0 = end0 + st * EXT_W'(wr - WRAP_W'(1));
    end
    err_o = zero_bad || (end0 > EXT_W'(buf0_i)) || (end1 > EXT_W'(buf1_i));
  end
endmodule

// File: rtl/tile_addr_intile.sv
module tile_addr_intile #(
  parameter int DIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic [DIM_W-1:0] tile0_i,
  input  logic [DIM_W-1:0] tile1_i,
  output logic [DIM_W-1:0] i0_o,
  output logic [DIM_W-1:0] i1_o,
  output logic             tile_end_o
);
  logic end0, end1;

  assign end0       = (i0_o == tile0_i - DIM_W'(1));
  assign end1       = (i1_o == tile1_i - DIM_W'(1));
  assign tile_end_o = end0 && end1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i0_o <= '0;
      i1_o <= '0;
    end else if (clear_i) begin
      i0_o <= '0;
      i1_o <= '0;
    end else if (adv_i) begin
      if (end0) begin
        i0_o <= '0;
        i1_o <= end1 ? '0 : i1_o + DIM_W'(1);
      end else begin
        i0_o <= i0_o + DIM_W'(1);
      end
    end
  end
endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker #(
  parameter int DIM_W   = 8,
  parameter int WRAP_W  = 4,
  parameter int NUM_LVL = 2,
  parameter int EXT_W   = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      adv_i,
  input  logic [NUM_LVL-1:0]        dim_i,
  input  logic [NUM_LVL*DIM_W-1:0]  stride_i,
  input  logic [NUM_LVL*WRAP_W-1:0] wrap_i,
  output logic [EXT_W-1:0]          org0_o,
  output logic [EXT_W-1:0]          org1_o,
  output logic                      last_tile_o
);
  logic [NUM_LVL-1:0]       carry;
  logic [NUM_LVL-1:0]       at_end;
  logic [NUM_LVL*DIM_W-1:0] pos_flat;

  assign carry[0] = adv_i;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [WRAP_W-1:0] cnt_q;
    logic [DIM_W-1:0]  pos_q;
    logic [WRAP_W-1:0] wr;
    logic [DIM_W-1:0]  st;

    assign wr        = wrap_i[l*WRAP_W +: WRAP_W];
    assign st        = stride_i[l*DIM_W +: DIM_W];
    assign at_end[l] = (cnt_q == wr - WRAP_W'(1));
    assign pos_flat[l*DIM_W +: DIM_W] = pos_q;

    if (l < NUM_LVL - 1) begin : g_carry
      assign carry[l+1] = carry[l] && at_end[l];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        pos_q <= '0;
      end else if (clear_i) begin
        cnt_q <= '0;
        pos_q <= '0;
      end else if (carry[l]) begin
        if (at_end[l]) begin
          cnt_q <= '0;
          pos_q <= '0;
        end else begin
          cnt_q <= cnt_q + WRAP_W'(1);
          pos_q <= pos_q + st;
        end
      end
    end
  end

  always_comb begin
    org0_o = '0;
    org1_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (dim_i[l]) org1_o = org1_o + EXT_W'(pos_flat[l*DIM_W +: DIM_W]);
      else          org0_o = org0_o + EXT_W'(pos_flat[l*DIM_W +: DIM_W]);
    end
  end

  assign last_tile_o = &at_end;
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int DIM_W   = 8,
  parameter int WRAP_W  = 4,
  parameter int NUM_LVL = 2,
  localparam int ADDR_W = 2 * DIM_W,
  localparam int EXT_W  = DIM_W + WRAP_W + $clog2(NUM_LVL + 2) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [DIM_W-1:0]          buf_dim0_i,
  input  logic [DIM_W-1:0]          buf_dim1_i,
  input  logic [DIM_W-1:0]          tile_dim0_i,
  input  logic [DIM_W-1:0]          tile_dim1_i,
  input  logic [DIM_W-1:0]          offset0_i,
  input  logic [DIM_W-1:0]          offset1_i,
  input  logic [NUM_LVL-1:0]        trav_dim_i,
  input  logic [NUM_LVL*DIM_W-1:0]  trav_stride_i,
  input  logic [NUM_LVL*WRAP_W-1:0] trav_wrap_i,
  input  logic                      ready_i,
  output logic                      valid_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      tile_last_o,
  output logic                      last_o,
  output logic                      busy_o,
  output logic                      cfg_err_o
);
  import tile_addr_pkg::*;

  state_e state_q;
  logic [DIM_W-1:0]          buf0_q, buf1_q, tile0_q, tile1_q, off0_q, off1_q;
  logic [NUM_LVL-1:0]        dim_q;
  logic [NUM_LVL*DIM_W-1:0]  stride_q;
  logic [NUM_LVL*WRAP_W-1:0] wrap_q;
  logic                      err_q;

  logic             cfg_bad, fire, clear, tile_end, last_tile;
  logic [DIM_W-1:0] i0, i1;
  logic [EXT_W-1:0] org0, org1, x, y;

  tile_addr_cfg_check #(
    .DIM_W(DIM_W), .WRAP_W(WRAP_W), .NUM_LVL(NUM_LVL), .EXT_W(EXT_W)
  ) u_check (
    .buf0_i(buf0_q), .buf1_i(buf1_q), .tile0_i(tile0_q), .tile1_i(tile1_q),
    .off0_i(off0_q), .off1_i(off1_q), .dim_i(dim_q), .stride_i(stride_q),
    .wrap_i(wrap_q), .err_o(cfg_bad)
  );

  tile_addr_intile #(.DIM_W(DIM_W)) u_intile (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .adv_i(fire),
    .tile0_i(tile0_q), .tile1_i(tile1_q), .i0_o(i0), .i1_o(i1),
    .tile_end_o(tile_end)
  );

  tile_addr_walker #(
    .DIM_W(DIM_W), .WRAP_W(WRAP_W), .NUM_LVL(NUM_LVL), .EXT_W(EXT_W)
  ) u_walker (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .adv_i(fire && tile_end),
    .dim_i(dim_q), .stride_i(stride_q), .wrap_i(wrap_q),
    .org0_o(org0), .org1_o(org1), .last_tile_o(last_tile)
  );

  assign clear       = (state_q == ST_CHECK);
  assign valid_o     = (state_q == ST_RUN);
  assign busy_o      = (state_q != ST_IDLE);
  assign fire        = valid_o && ready_i;
  assign tile_last_o = valid_o && tile_end;
  assign last_o      = valid_o && tile_end && last_tile;
  assign cfg_err_o   = err_q;

  assign x      = EXT_W'(off0_q) + org0 + EXT_W'(i0);
  assign y      = EXT_W'(off1_q) + org1 + EXT_W'(i1);
  assign addr_o = ADDR_W'(x) + ADDR_W'(y) * ADDR_W'(buf0_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      err_q    <= 1'b0;
      buf0_q   <= '0;
      buf1_q   <= '0;
      tile0_q  <= '0;
      tile1_q  <= '0;
      off0_q   <= '0;
      off1_q   <= '0;
      dim_q    <= '0;
      stride_q <= '0;
      wrap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_CHECK;
          err_q    <= 1'b0;
          buf0_q   <= buf_dim0_i;
          buf1_q   <= buf_dim1_i;
          tile0_q  <= tile_dim0_i;
          tile1_q  <= tile_dim1_i;
          off0_q   <= offset0_i;
          off1_q   <= offset1_i;
          dim_q    <= trav_dim_i;
          stride_q <= trav_stride_i;
          wrap_q   <= trav_wrap_i;
        end
        ST_CHECK: begin
          if (cfg_bad) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: if (fire && last_o) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_addr_gen_sva.sv
module tile_addr_gen_sva #(
  parameter int DIM_W  = 8,
  localparam int ADDR_W = 2 * DIM_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tile_last_i,
  input logic              last_i,
  input logic              busy_i,
  input logic              cfg_err_i,
  input logic [DIM_W-1:0]  buf0_i,
  input logic [DIM_W-1:0]  buf1_i
);
  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(addr_i) && $stable(last_i) && $stable(tile_last_i));

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i && last_i |=> !busy_i && !valid_i);

  assert_valid_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> busy_i);

  assert_err_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_i |-> !valid_i);

  assert_in_buffer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> addr_i < ADDR_W'(buf0_i) * ADDR_W'(buf1_i));

  assert_last_ends_tile_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |-> tile_last_i);
endmodule

bind tile_addr_gen tile_addr_gen_sva #(.DIM_W(DIM_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_o), .ready_i(ready_i),
  .addr_i(addr_o), .tile_last_i(tile_last_o), .last_i(last_o),
  .busy_i(busy_o), .cfg_err_i(cfg_err_o), .buf0_i(buf0_q), .buf1_i(buf1_q)
);

// File: tb/tile_addr_gen_test.sv
`timescale 1ns/1ps
module tile_addr_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  buf_dim0_i = '0, buf_dim1_i = '0, tile_dim0_i = '0, tile_dim1_i = '0;
  logic [7:0]  offset0_i = '0, offset1_i = '0;
  logic [1:0]  trav_dim_i = '0;
  logic [15:0] trav_stride_i = '0;
  logic [7:0]  trav_wrap_i = '0;
  logic        ready_i = 1'b0;
  logic        valid_o, tile_last_o, last_o, busy_o, cfg_err_o;
  logic [15:0] addr_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_addr [0:4095];
  bit exp_tl   [0:4095];
  bit exp_last [0:4095];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  tile_addr_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .buf_dim0_i(buf_dim0_i), .buf_dim1_i(buf_dim1_i),
    .tile_dim0_i(tile_dim0_i), .tile_dim1_i(tile_dim1_i),
    .offset0_i(offset0_i), .offset1_i(offset1_i),
    .trav_dim_i(trav_dim_i), .trav_stride_i(trav_stride_i), .trav_wrap_i(trav_wrap_i),
    .ready_i(ready_i), .valid_o(valid_o), .addr_o(addr_o),
    .tile_last_o(tile_last_o), .last_o(last_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // tag names the requirement the address comparison stands for
  task automatic run_case(input int b0, input int b1, input int t0, input int t1,
                          input int o0, input int o1,
                          input int d0, input int s0, input int w0,
                          input int d1, input int s1, input int w1,
                          input bit inject, input string tag);
    int n, e0, e1, idx, guard, held;
    bit bad, stalled, injected, r;
    n = 0;
    bad = (t0 == 0) || (t1 == 0) || (w0 == 0) || (w1 == 0);
    if (!bad) begin
      e0 = o0 + t0 + (d0 == 0 ? s0 * (w0 - 1) : 0) + (d1 == 0 ? s1 * (w1 - 1) : 0);
      e1 = o1 + t1 + (d0 == 1 ? s0 * (w0 - 1) : 0) + (d1 == 1 ? s1 * (w1 - 1) : 0);
      bad = (e0 > b0) || (e1 > b1);
    end
    if (!bad) begin
      for (int c1 = 0; c1 < w1; c1++)
        for (int c0 = 0; c0 < w0; c0++)
          for (int i1 = 0; i1 < t1; i1++)
            for (int i0 = 0; i0 < t0; i0++) begin
              int g0, g1;
              g0 = (d0 == 0 ? c0 * s0 : 0) + (d1 == 0 ? c1 * s1 : 0);
              g1 = (d0 == 1 ? c0 * s0 : 0) + (d1 == 1 ? c1 * s1 : 0);
              exp_addr[n] = (o0 + g0 + i0) + (o1 + g1 + i1) * b0;
              exp_tl[n]   = (i0 == t0 - 1) && (i1 == t1 - 1);
              exp_last[n] = exp_tl[n] && (c0 == w0 - 1) && (c1 == w1 - 1);
              n++;
            end
    end
    @(negedge clk_i);
    buf_dim0_i = 8'(b0); buf_dim1_i = 8'(b1);
    tile_dim0_i = 8'(t0); tile_dim1_i = 8'(t1);
    offset0_i = 8'(o0); offset1_i = 8'(o1);
    trav_dim_i = {1'(d1), 1'(d0)};
    trav_stride_i = {8'(s1), 8'(s0)};
    trav_wrap_i = {4'(w1), 4'(w0)};
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    idx = 0; guard = 0; stalled = 0; injected = 0; held = 0;
    while (busy_o && guard < 5000) begin
      if (start_i) begin
        start_i = 1'b0;
        tile_dim0_i = 8'(t0);
        offset0_i = 8'(o0);
      end
      if (stalled) chk(valid_o && int'(addr_o) == held, "R7 held address", int'(addr_o), held);
      stalled = 0;
      r = ((cyc * 3 + idx) % 4) != 1;
      ready_i = r;
      if (valid_o) begin
        if (idx < n) begin
          chk(int'(addr_o) == exp_addr[idx], tag, int'(addr_o), exp_addr[idx]);
          chk(tile_last_o == exp_tl[idx], "R6 tile_last", int'(tile_last_o), int'(exp_tl[idx]));
          chk(last_o == exp_last[idx], "R5 last", int'(last_o), int'(exp_last[idx]));
        end else begin
          chk(1'b0, "R5 extra address", idx, n);
        end
        if (r) idx++;
        else begin
          stalled = 1;
          held = int'(addr_o);
        end
      end
      if (inject && !injected && idx == 2) begin
        injected = 1;
        start_i = 1'b1;
        tile_dim0_i = 8'd0;      // would be a config error if accepted
        offset0_i = 8'd200;
      end
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    chk(guard < 5000, "R5 completion", guard, 5000);
    chk(idx == n, "R5 count", idx, n);
    chk(cfg_err_o == bad, "R8 cfg_err", int'(cfg_err_o), int'(bad));
    if (inject) chk(idx == n && !cfg_err_o, "R9 start while busy", idx, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!valid_o && !busy_o && !cfg_err_o, "R1 reset state",
        int'({valid_o, busy_o, cfg_err_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!valid_o && !busy_o && !cfg_err_o, "R1 after release",
        int'({valid_o, busy_o, cfg_err_o}), 0);

    // column-wise 4x3 tiles over 12x8
    run_case(12, 8, 4, 3, 0, 0, 1, 3, 2, 0, 4, 3, 1'b0, "R3 column-wise");
    // row-wise overlapping 7x2 tiles over 12x8
    run_case(12, 8, 7, 2, 0, 0, 0, 5, 2, 1, 2, 3, 1'b0, "R4 overlap row-wise");
    // offsets
    run_case(12, 8, 3, 2, 2, 1, 0, 4, 2, 1, 3, 2, 1'b0, "R2 offset");
    // start pulse while streaming
    run_case(12, 8, 4, 3, 0, 0, 1, 3, 2, 0, 4, 3, 1'b1, "R9 stream");
    // out of range by one along dimension 0
    run_case(12, 8, 4, 3, 1, 0, 1, 3, 2, 0, 4, 3, 1'b0, "R8 range");
    // zero wrap count
    run_case(12, 8, 4, 3, 0, 0, 1, 3, 0, 0, 4, 3, 1'b0, "R8 zero wrap");
    // error flag cleared by next good start
    run_case(12, 8, 2, 2, 0, 0, 0, 2, 3, 1, 2, 2, 1'b0, "R8 clear then R2");
    // exactly filling the buffer edge
    run_case(12, 8, 4, 2, 0, 0, 0, 4, 3, 1, 2, 4, 1'b0, "R3 edge fit");

    for (int t0 = 1; t0 <= 3; t0++)
      for (int t1 = 1; t1 <= 3; t1++)
        for (int s0 = 1; s0 <= 3; s0++)
          for (int s1 = 1; s1 <= 3; s1++)
            for (int w0 = 1; w0 <= 2; w0++)
              for (int w1 = 1; w1 <= 2; w1++)
                for (int dm = 0; dm < 3; dm++)
                  run_case(8, 8, t0, t1, (t0 + s0) % 3, s1 % 2,
                           dm == 1 ? 1 : 0, s0, w0, dm == 2 ? 0 : 1 - (dm == 1 ? 1 : 0), s1, w1,
                           1'b0, "R2 sweep address");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule